// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Driver

This block shows an 8-bit value as two hexadecimal digits on a seven-segment display with shared segment lines. The two digits share the seven segment wires, and one select output picks which digit is lit. The block switches between the digits often enough that both appear lit at once.

A free-running prescaler produces a single-cycle strobe once per period. With a 100 MHz clock and the default terminal count of 99999, the period is 1 ms. Each strobe inverts the digit-select register, so the select output is a 500 Hz square wave. The select level also chooses which nibble of the input goes to a hex-to-glyph decoder. The decoder output drives the segment lines directly, so the glyph and the select line change in the same cycle. The low nibble appears on the right-hand digit (select low) and the high nibble on the left-hand digit (select high).

Top module: `hex2_scan_display`

## Requirements
- R1: A synchronous active-high reset sets the digit-select output to 0. While reset is held, the segments show the glyph of the low nibble.
- R2: After reset is released, the digit-select output first inverts TERM_COUNT+1 clock edges later. It then inverts once every TERM_COUNT+1 edges and holds its level between inversions.
- R3: The internal strobe is high for exactly one cycle per period, on the cycle where the prescaler holds TERM_COUNT. The prescaler then wraps to 0.
- R4: With digit-select at 0, the segments show input bits 3:0 (right digit). With digit-select at 1, they show input bits 7:4 (left digit).
- R5: Segment outputs are active high, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. The glyphs for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex).
- R6: The segments depend only on the select level and the input. They update in the same cycle that the select level or the input changes, with no register delay.
- R7: Asserting reset part way through a period restarts the timing. The next inversion comes TERM_COUNT+1 edges after release.
- R8: The prescaler count never exceeds TERM_COUNT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz in the target system) |
| rst | input | 1 | Synchronous reset, active high |
| hex_pair | input | 8 | Two hex digits: bits 7:4 left, bits 3:0 right |
| seg | output | 7 | Segment lines a..g, active high, bit 0 = a |
| digit_sel | output | 1 | Digit select: 0 = right digit, 1 = left digit |

## Verification
The hardest case to reach from the ports is the exact cycle where digit-select inverts. In that cycle the glyph must switch nibbles with no lag. A one-cycle slip would briefly light the wrong digit, and a slow clock view would hide it. The bench builds the block with a terminal count of 4 and tracks the expected select phase with its own cycle counter. It then checks the segments in the very cycle of each inversion and sweeps all 16 glyphs through both nibble positions. A mid-period reset confirms that the cadence restarts from zero.

// File: rtl/hex2_disp_pkg.sv
package hex2_disp_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] glyph_t;
  typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
  parameter int TERM_COUNT = 99999
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int CNT_W = (TERM_COUNT < 1) ? 1 : $clog2(TERM_COUNT + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_COUNT);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (count_q == TERM) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  assign strobe = (count_q == TERM);

  // R8: count stays within its period
  a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= TERM);
  // R3: strobe is followed by a wrap to zero
  a_r3_wrap_after_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (count_q == '0));
  // R3: no strobe means the count advanced by one
  a_r3_step_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/digit_toggle.sv
module digit_toggle (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= 1'b0;
    end else if (strobe) begin
      sel <= ~sel;
    end
  end

  // R2: select inverts on each strobe
  a_r2_invert_on_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (sel != $past(sel)));
  // R2: select holds between strobes
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(sel));
endmodule

// File: rtl/hex_glyph.sv
module hex_glyph
  import hex2_disp_pkg::*;
(
  input  nibble_t value,
  output glyph_t  glyph
);
  always_comb begin
    unique case (value)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  end
endmodule

// File: rtl/hex2_scan_display.sv
module hex2_scan_display
  import hex2_disp_pkg::*;
#(
  parameter int TERM_COUNT = 99999
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NIB_W-1:0]   hex_pair,
  output logic [SEG_W-1:0]     seg,
  output logic                 digit_sel
);
  logic    strobe;
  nibble_t shown;

  scan_prescaler #(.TERM_COUNT(TERM_COUNT)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  digit_toggle u_toggle (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .sel    (digit_sel)
  );

  // Select high picks the left (upper) nibble, low picks the right one.
  assign shown = digit_sel ? hex_pair[2*NIB_W-1:NIB_W] : hex_pair[NIB_W-1:0];

  hex_glyph u_glyph (
    .value (shown),
    .glyph (seg)
  );

  // R1: reset leaves the right digit selected
  a_r1_reset_selects_right: assert property (@(posedge clk)
    rst |=> !digit_sel);
  // R6: with select and input steady, segments are steady
  a_r6_segments_steady: assert property (@(posedge clk) disable iff (rst)
    ($stable(digit_sel) && $stable(hex_pair)) |-> $stable(seg));
  // R5: every hex glyph lights at least two segments
  a_r5_glyph_nonblank: assert property (@(posedge clk) disable iff (rst)
    $countones(seg) >= 2);
endmodule

// File: tb/test_hex2_scan_display.sv
module test_hex2_scan_display;
  localparam int TERM = 4;
  localparam int PER  = TERM + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hex_pair = 8'h00;
  logic [6:0] seg;
  logic       digit_sel;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  hex2_scan_display #(.TERM_COUNT(TERM)) i_hex2_scan_display (
    .clk(clk), .rst(rst), .hex_pair(hex_pair), .seg(seg), .digit_sel(digit_sel)
  );

  function automatic logic [6:0] ref_glyph(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic exp_sel();
    return ((cyc / PER) % 2) == 1;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic t_reset_state();
    hex_pair = 8'hA5;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sel", {6'd0, digit_sel}, 7'd0);
    check("R1 seg", seg, ref_glyph(4'h5));
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic t_cadence();
    do_reset();
    for (int k = 1; k <= 4 * PER; k++) begin
      step();
      check("R2 cadence", {6'd0, digit_sel}, {6'd0, exp_sel()});
    end
  endtask

  task automatic t_routing_same_cycle();
    do_reset();
    hex_pair = 8'h3C;
    for (int k = 1; k <= 2 * PER + 1; k++) begin
      step();
      #1;
      // R4 and R6: glyph follows the select in the very cycle it flips
      check("R4/R6 routing", seg, exp_sel() ? ref_glyph(4'h3) : ref_glyph(4'hC));
    end
  endtask

  task automatic t_all_glyphs();
    do_reset();
    for (int v = 0; v < 16; v++) begin
      for (int half = 0; half < 2; half++) begin
        while (exp_sel() != half[0]) step();
        hex_pair = half == 1 ? {v[3:0], ~v[3:0]} : {~v[3:0], v[3:0]};
        #1;
        check("R5 glyph", seg, ref_glyph(v[3:0]));
        step();
      end
    end
  endtask

  task automatic t_input_change_midcycle();
    do_reset();
    hex_pair = 8'h12;
    step();
    #1;
    check("R6 before", seg, ref_glyph(4'h2));
    hex_pair = 8'h19;
    #1;
    check("R6 no clock", seg, ref_glyph(4'h9));
  endtask

  task automatic t_midrun_reset();
    do_reset();
    repeat (PER + 2) step();
    check("R7 pre", {6'd0, digit_sel}, 7'd1);
    do_reset();
    repeat (TERM) step();
    check("R7 hold", {6'd0, digit_sel}, 7'd0);
    step();
    check("R7 flip", {6'd0, digit_sel}, 7'd1);
  endtask

  initial begin
    t_reset_state();
    t_cadence();
    t_routing_same_cycle();
    t_all_glyphs();
    t_input_change_midcycle();
    t_midrun_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog (R2) actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule